// File: doc/BRIEF.md
# NOR Flash Operation Sequencer

This block sits on the host side of a parallel NOR flash and turns one high-level request into the series of command writes and data reads that the device expects. Five operations are accepted: return to read-array mode, identifier read, single-word program, erase of one block, and erase of the whole device. For program and erase the sequencer polls the device status word until the ready flag rises. It then decodes the error flags and reports the result as a one-cycle completion pulse carrying a 2-bit result code.

An erase first queries the block's lock state and unlocks the block if needed. The device has no single whole-chip erase command, so a chip erase becomes a block erase for each block in ascending order, and the first failing block ends the run. A poll timeout stops the wait if the ready flag never rises. The block count, the block size in words and the timeout are parameters. Block size must be a power of two.

The device-side bus is a request/acknowledge handshake. The sequencer holds `fl_req` with stable `fl_we`, `fl_addr` and `fl_wdata` until the device returns a one-cycle `fl_ack`. On a read, `fl_rdata` is valid in the `fl_ack` cycle. The next access may start in the cycle after `fl_ack`.

Top module: `nfs_sequencer`

## Requirements
- R1: Every accepted request first writes 0x00FF at its working address: the request address, or the block base for an erase. The last write of every request, pass or fail, is 0x00FF, so the device is left in read-array mode.
- R2: An access holds `fl_req`, `fl_we`, `fl_addr` and `fl_wdata` stable until `fl_ack`, and each `fl_ack` completes exactly one access.
- R3: The identifier read (`req_op`=1) writes 0x0090 at the request address, reads that address and puts the word on `id_word`, then writes 0x00FF. The result code is 0.
- R4: An erase reads the lock word at block base + 2 after writing 0x0090 there, then writes 0x00FF. When bit 0 of the lock word is 1, it writes 0x0060 and then 0x00D0 to the block base, followed by 0x00FF.
- R5: A program (`req_op`=2) writes 0x0010 and then the data word at the request address, then polls. On success it writes 0x0050 and then 0x00FF, and reports code 0.
- R6: Polling writes 0x0070 and reads one status word, and repeats until status bit 7 is 1. A program then fails with code 1 when bit 1, 3 or 4 is set. Bit 5 does not affect a program.
- R7: A block erase (`req_op`=3, block = address bits above the block offset) writes 0x0050, 0x0020 and 0x00D0 to the block base, then polls. It fails with code 2 when bit 1, 3, 4 or 5 is set once ready.
- R8: A chip erase (`req_op`=4) erases blocks 0 through BLK_CNT-1 in order. It stops after the first failing block with code 2, and later blocks are not touched.
- R9: When POLL_LIMIT consecutive status reads show bit 7 clear, the operation ends. The result is code 1 for a program or code 2 for an erase, followed by the closing 0x00FF.
- R10: `done` is a one-cycle pulse. `busy` is high from the cycle after acceptance until `done`. A request is taken only when `busy` is low, `req_valid` is high and `req_op` is 0 to 4. Reset (`op` 0) writes only 0x00FF and reports code 0. After reset, `busy`, `done` and `fl_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 3 | Operation: 0 reset, 1 identifier, 2 program, 3 block erase, 4 chip erase |
| req_addr | input | ADDR_W | Word address of the operation |
| req_data | input | DATA_W | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 write failure, 2 erase failure; valid with done |
| id_word | output | DATA_W | Last identifier word read |
| fl_req | output | 1 | Device access request |
| fl_we | output | 1 | 1 write, 0 read |
| fl_addr | output | ADDR_W | Device word address |
| fl_wdata | output | DATA_W | Command or data word |
| fl_ack | input | 1 | Access complete |
| fl_rdata | input | DATA_W | Read word, valid with fl_ack |

## Verification
The bench builds the sequencer with four blocks of sixteen words, an 8-bit address and a poll limit of eight. This makes a full chip erase and a full-block erase check cheap to observe word by word. It also puts both edges of the timeout within a short run: seven busy reads still pass, while a device that never becomes ready hits the limit. With four blocks, a chip erase can fail on an inner block and leave both earlier and later blocks to inspect.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

    typedef enum logic [2:0] {
        OP_RESET      = 3'd0,
        OP_READ_ID    = 3'd1,
        OP_PROGRAM    = 3'd2,
        OP_ERASE_BLK  = 3'd3,
        OP_ERASE_CHIP = 3'd4
    } op_e;

    localparam logic [1:0] RES_OK        = 2'd0;
    localparam logic [1:0] RES_WRITE_ERR = 2'd1;
    localparam logic [1:0] RES_ERASE_ERR = 2'd2;

    localparam logic [7:0] CMD_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;
    localparam logic [7:0] CMD_LOCKCFG = 8'h60;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_PROG    = 8'h10;

    localparam int SR_READY     = 7;
    localparam int SR_ERASE_BAD = 5;
    localparam int SR_PROG_BAD  = 4;
    localparam int SR_VOLT_BAD  = 3;
    localparam int SR_LOCK_BAD  = 1;

    localparam int LOCK_FLAG   = 0;
    localparam int LOCK_OFFSET = 2;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_PRE_RST,
        ST_ID_CMD,
        ST_ID_RD,
        ST_PG_SETUP,
        ST_PG_DATA,
        ST_LK_CMD,
        ST_LK_RD,
        ST_LK_RST,
        ST_UL_SETUP,
        ST_UL_CONF,
        ST_UL_RST,
        ST_ER_CLR,
        ST_ER_SETUP,
        ST_ER_CONF,
        ST_POLL_CMD,
        ST_POLL_RD,
        ST_CLR_OK,
        ST_POST_RST
    } step_e;

endpackage

// File: rtl/nfs_status_eval.sv
module nfs_status_eval #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] sr_word,
    output logic              sr_ready,
    output logic              prog_bad,
    output logic              erase_bad
);
    import nfs_pkg::*;

    logic common_bad;

    always_comb begin
        sr_ready   = sr_word[SR_READY];
        common_bad = sr_word[SR_LOCK_BAD] | sr_word[SR_VOLT_BAD] | sr_word[SR_PROG_BAD];
        prog_bad   = common_bad;
        erase_bad  = common_bad | sr_word[SR_ERASE_BAD];
    end

endmodule

// File: rtl/nfs_poll_timer.sv
module nfs_poll_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick && cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == LAST);

    AST_TMR_NO_TICK_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr) |-> !tick) else $error("tick after expiry"); // R9
    AST_TMR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)) else $error("timer not cleared"); // R9

endmodule

// File: rtl/nfs_bus_port.sv
module nfs_bus_port #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              step_valid,
    input  logic              step_we,
    input  logic [ADDR_W-1:0] step_addr,
    input  logic [DATA_W-1:0] step_wdata,
    output logic              step_done,
    output logic              fl_req,
    output logic              fl_we,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic              fl_ack
);
    always_comb begin
        fl_req    = step_valid;
        fl_we     = step_valid & step_we;
        fl_addr   = step_valid ? step_addr : '0;
        fl_wdata  = (step_valid && step_we) ? step_wdata : '0;
        step_done = step_valid & fl_ack;
    end

endmodule

// File: rtl/nfs_sequencer.sv
module nfs_sequencer #(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int BLK_CNT    = 8,
    parameter int BLK_WORDS  = 4096,
    parameter int POLL_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic [DATA_W-1:0] id_word,
    output logic              fl_req,
    output logic              fl_we,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic              fl_ack,
    input  logic [DATA_W-1:0] fl_rdata
);
    import nfs_pkg::*;

    localparam int BLK_SH = $clog2(BLK_WORDS);
    localparam int BLK_IW = (BLK_CNT > 1) ? $clog2(BLK_CNT) : 1;
    localparam logic [BLK_IW-1:0] LAST_BLK = BLK_IW'(BLK_CNT - 1);

    typedef struct packed {
        step_e             st;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BLK_IW-1:0] blk;
        logic              locked;
        logic [1:0]        res;
        logic              done;
        logic [DATA_W-1:0] id;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              step_valid, step_we, step_done;
    logic [ADDR_W-1:0] step_addr;
    logic [DATA_W-1:0] step_wdata;
    logic [ADDR_W-1:0] blk_base, work_addr;
    logic              is_erase;
    logic              sr_ready, prog_bad, erase_bad;
    logic              tmr_clr, tmr_tick, tmr_expired;

    nfs_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .step_valid (step_valid),
        .step_we    (step_we),
        .step_addr  (step_addr),
        .step_wdata (step_wdata),
        .step_done  (step_done),
        .fl_req     (fl_req),
        .fl_we      (fl_we),
        .fl_addr    (fl_addr),
        .fl_wdata   (fl_wdata),
        .fl_ack     (fl_ack)
    );

    nfs_status_eval #(.DATA_W(DATA_W)) u_eval (
        .sr_word   (fl_rdata),
        .sr_ready  (sr_ready),
        .prog_bad  (prog_bad),
        .erase_bad (erase_bad)
    );

    nfs_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .tick    (tmr_tick),
        .expired (tmr_expired)
    );

    always_comb begin
        is_erase  = (ctl_q.op == OP_ERASE_BLK) || (ctl_q.op == OP_ERASE_CHIP);
        blk_base  = ADDR_W'(ctl_q.blk) << BLK_SH;
        work_addr = is_erase ? blk_base : ctl_q.addr;
    end

    // Bus access implied by the current step
    always_comb begin
        step_valid = (ctl_q.st != ST_IDLE);
        step_we    = 1'b1;
        step_addr  = work_addr;
        step_wdata = DATA_W'(CMD_ARRAY);
        case (ctl_q.st)
            ST_ID_CMD:   step_wdata = DATA_W'(CMD_IDENT);
            ST_ID_RD:    step_we    = 1'b0;
            ST_PG_SETUP: step_wdata = DATA_W'(CMD_PROG);
            ST_PG_DATA:  step_wdata = ctl_q.data;
            ST_LK_CMD: begin
                step_addr  = blk_base | ADDR_W'(LOCK_OFFSET);
                step_wdata = DATA_W'(CMD_IDENT);
            end
            ST_LK_RD: begin
                step_addr = blk_base | ADDR_W'(LOCK_OFFSET);
                step_we   = 1'b0;
            end
            ST_UL_SETUP: step_wdata = DATA_W'(CMD_LOCKCFG);
            ST_UL_CONF:  step_wdata = DATA_W'(CMD_CONFIRM);
            ST_ER_CLR:   step_wdata = DATA_W'(CMD_CLEAR);
            ST_ER_SETUP: step_wdata = DATA_W'(CMD_ERASE);
            ST_ER_CONF:  step_wdata = DATA_W'(CMD_CONFIRM);
            ST_POLL_CMD: step_wdata = DATA_W'(CMD_STATUS);
            ST_POLL_RD:  step_we    = 1'b0;
            ST_CLR_OK:   step_wdata = DATA_W'(CMD_CLEAR);
            default:     step_wdata = DATA_W'(CMD_ARRAY);
        endcase
    end

    // Next-state computation
    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_clr    = 1'b0;
        tmr_tick   = 1'b0;
        if (ctl_q.st == ST_IDLE) begin
            if (req_valid && req_op <= 3'd4) begin
                ctl_d.st   = ST_PRE_RST;
                ctl_d.op   = op_e'(req_op);
                ctl_d.addr = req_addr;
                ctl_d.data = req_data;
                ctl_d.res  = RES_OK;
                ctl_d.blk  = (op_e'(req_op) == OP_ERASE_CHIP) ? '0
                                                              : req_addr[BLK_SH +: BLK_IW];
            end
        end else if (step_done) begin
            case (ctl_q.st)
                ST_PRE_RST: begin
                    case (ctl_q.op)
                        OP_RESET: begin
                            ctl_d.st   = ST_IDLE;
                            ctl_d.done = 1'b1;
                        end
                        OP_READ_ID: ctl_d.st = ST_ID_CMD;
                        OP_PROGRAM: ctl_d.st = ST_PG_SETUP;
                        default:    ctl_d.st = ST_LK_CMD;
                    endcase
                end
                ST_ID_CMD:   ctl_d.st = ST_ID_RD;
                ST_ID_RD: begin
                    ctl_d.id = fl_rdata;
                    ctl_d.st = ST_POST_RST;
                end
                ST_PG_SETUP: ctl_d.st = ST_PG_DATA;
                ST_PG_DATA: begin
                    tmr_clr  = 1'b1;
                    ctl_d.st = ST_POLL_CMD;
                end
                ST_LK_CMD:   ctl_d.st = ST_LK_RD;
                ST_LK_RD: begin
                    ctl_d.locked = fl_rdata[LOCK_FLAG];
                    ctl_d.st     = ST_LK_RST;
                end
                ST_LK_RST:   ctl_d.st = ctl_q.locked ? ST_UL_SETUP : ST_ER_CLR;
                ST_UL_SETUP: ctl_d.st = ST_UL_CONF;
                ST_UL_CONF:  ctl_d.st = ST_UL_RST;
                ST_UL_RST:   ctl_d.st = ST_ER_CLR;
                ST_ER_CLR:   ctl_d.st = ST_ER_SETUP;
                ST_ER_SETUP: ctl_d.st = ST_ER_CONF;
                ST_ER_CONF: begin
                    tmr_clr  = 1'b1;
                    ctl_d.st = ST_POLL_CMD;
                end
                ST_POLL_CMD: ctl_d.st = ST_POLL_RD;
                ST_POLL_RD: begin
                    if (!sr_ready) begin
                        if (tmr_expired) begin
                            ctl_d.res = is_erase ? RES_ERASE_ERR : RES_WRITE_ERR;
                            ctl_d.st  = ST_POST_RST;
                        end else begin
                            tmr_tick = 1'b1;
                            ctl_d.st = ST_POLL_CMD;
                        end
                    end else if (!is_erase) begin
                        if (prog_bad) begin
                            ctl_d.res = RES_WRITE_ERR;
                            ctl_d.st  = ST_POST_RST;
                        end else begin
                            ctl_d.st = ST_CLR_OK;
                        end
                    end else begin
                        if (erase_bad) begin
                            ctl_d.res = RES_ERASE_ERR;
                        end
                        ctl_d.st = ST_POST_RST;
                    end
                end
                ST_CLR_OK: ctl_d.st = ST_POST_RST;
                ST_POST_RST: begin
                    if (ctl_q.op == OP_ERASE_CHIP && ctl_q.res == RES_OK &&
                        ctl_q.blk != LAST_BLK) begin
                        ctl_d.blk = ctl_q.blk + 1'b1;
                        ctl_d.st  = ST_PRE_RST;
                    end else begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end
                end
                default: ctl_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, op: OP_RESET, addr: '0, data: '0, blk: '0,
                       locked: 1'b0, res: RES_OK, done: 1'b0, id: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy    = (ctl_q.st != ST_IDLE);
    assign done    = ctl_q.done;
    assign result  = ctl_q.res;
    assign id_word = ctl_q.id;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_we) && $stable(fl_addr) && $stable(fl_wdata)))
        else $error("access dropped or changed before ack"); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fl_req) else $error("bus access while idle"); // R10
    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done while busy"); // R10
    AST_WRITE_ERR_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_WRITE_ERR) |-> (ctl_q.op == OP_PROGRAM))
        else $error("write failure on non-program"); // R6
    AST_ERASE_ERR_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_ERASE_ERR) |-> is_erase)
        else $error("erase failure on non-erase"); // R7
    AST_LAST_WRITE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(fl_we) && $past(fl_wdata) == DATA_W'(CMD_ARRAY)))
        else $error("final access not read-array"); // R1
    AST_CHIP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && ctl_q.op == OP_ERASE_CHIP && ctl_q.blk != $past(ctl_q.blk))
            |-> (ctl_q.blk == $past(ctl_q.blk) + 1'b1))
        else $error("chip erase block order"); // R8

endmodule

// File: tb/tb_nfs_sequencer.sv
module tb_nfs_sequencer;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NB = 4;
    localparam int BW = 16;
    localparam int PL = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          busy, done;
    logic [1:0]    result;
    logic [DW-1:0] id_word;
    logic          fl_req, fl_we;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic          fl_ack = 1'b0;
    logic [DW-1:0] fl_rdata = '0;

    always #4 clk = ~clk;

    nfs_sequencer #(.ADDR_W(AW), .DATA_W(DW), .BLK_CNT(NB), .BLK_WORDS(BW),
                    .POLL_LIMIT(PL)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .result(result), .id_word(id_word), .fl_req(fl_req), .fl_we(fl_we),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_ack(fl_ack), .fl_rdata(fl_rdata)
    );

    // ---------------- device model ----------------
    logic [15:0] mem [64];
    logic [NB-1:0] lock;
    logic [15:0] log_d [1024];
    logic [7:0]  log_a [1024];
    int n_wr = 0, n_sread = 0, n_clr = 0, n_unl = 0;
    int mode = 0;              // 0 array, 1 ident, 2 status
    logic pg_pend = 0, lk_pend = 0, er_pend = 0;
    logic [7:0] sr = 8'h00;
    int bleft = 0;
    // bench knobs
    logic          fill = 1'b0;
    logic [15:0]   fill_val = 16'h1111;
    logic [NB-1:0] lock_init = '0;
    logic [7:0]    inj = 8'h00;
    int            inj_blk = -1;
    int            bsy = 0;
    logic          hang = 1'b0;

    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < 64; i++) mem[i] = fill_val;
            lock = lock_init;
        end
        if (fl_req && !fl_ack) begin
            fl_ack <= 1'b1;
            if (fl_we) begin
                log_d[n_wr % 1024] = fl_wdata;
                log_a[n_wr % 1024] = fl_addr;
                n_wr++;
                if (pg_pend) begin
                    pg_pend = 1'b0;
                    sr = inj;
                    if ((inj & 8'h1A) == 8'h00) mem[fl_addr[5:0]] = fl_wdata;
                    bleft = bsy;
                    mode = 2;
                end else begin
                    case (fl_wdata[7:0])
                        8'hFF: begin mode = 0; lk_pend = 0; er_pend = 0; end
                        8'h90: mode = 1;
                        8'h70: mode = 2;
                        8'h50: begin sr = 8'h00; n_clr++; end
                        8'h60: lk_pend = 1'b1;
                        8'h20: er_pend = 1'b1;
                        8'h10: pg_pend = 1'b1;
                        8'hD0: begin
                            if (lk_pend) begin
                                lk_pend = 1'b0;
                                lock[fl_addr[5:4]] = 1'b0;
                                n_unl++;
                            end else if (er_pend) begin
                                er_pend = 1'b0;
                                mode = 2;
                                bleft = bsy;
                                if (lock[fl_addr[5:4]]) sr = sr | 8'h02;
                                else begin
                                    if (inj_blk < 0 || inj_blk == int'(fl_addr[5:4])) sr = sr | inj;
                                    if ((sr & 8'h3A) == 8'h00)
                                        for (int i = 0; i < BW; i++) mem[{fl_addr[5:4], 4'(i)}] = 16'hFFFF;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end else begin
                case (mode)
                    0: fl_rdata <= mem[fl_addr[5:0]];
                    1: case (fl_addr[3:0])
                           4'd0: fl_rdata <= 16'h0089;
                           4'd1: fl_rdata <= 16'h1234;
                           4'd2: fl_rdata <= {15'd0, lock[fl_addr[5:4]]};
                           default: fl_rdata <= 16'h0000;
                       endcase
                    default: begin
                        n_sread++;
                        fl_rdata <= {8'h00, (!hang && bleft == 0), sr[6:0]};
                        if (!hang && bleft > 0) bleft--;
                    end
                endcase
            end
        end else begin
            fl_ack <= 1'b0;
        end
    end

    // ---------------- checking ----------------
    int checks = 0, fails = 0;
    int s_wr, s_sr, s_clr, s_unl;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic prep(input logic [NB-1:0] lk, input logic [7:0] ij, input int ib,
                        input int b, input logic hg);
        @(negedge clk);
        lock_init = lk; inj = ij; inj_blk = ib; bsy = b; hang = hg;
        fill = 1'b1;
        @(negedge clk);
        fill = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int guard;
        s_wr = n_wr; s_sr = n_sread; s_clr = n_clr; s_unl = n_unl;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R10", "busy after accept", int'(busy), 1);
        guard = 0;
        while (done !== 1'b1 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 5000, "R10", "completion", guard, 0);
    endtask

    function automatic int wd(input int k);
        return int'(log_d[k % 1024]);
    endfunction

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  addr;
        logic [15:0] data;
        logic        lk;
        logic [7:0]  ij;
        logic [3:0]  b;
        logic [1:0]  res;
        logic [15:0] id;
    } vec_t;

    localparam vec_t VECS [13] = '{
        '{3'd1, 8'h00, 16'h0000, 1'b0, 8'h00, 4'd0, 2'd0, 16'h0089},
        '{3'd1, 8'h21, 16'h0000, 1'b0, 8'h00, 4'd0, 2'd0, 16'h1234},
        '{3'd1, 8'h32, 16'h0000, 1'b1, 8'h00, 4'd0, 2'd0, 16'h0001},
        '{3'd2, 8'h05, 16'hA5A5, 1'b0, 8'h00, 4'd3, 2'd0, 16'h0000},
        '{3'd2, 8'h06, 16'h5A5A, 1'b0, 8'h10, 4'd1, 2'd1, 16'h0000},
        '{3'd2, 8'h07, 16'h0F0F, 1'b0, 8'h08, 4'd0, 2'd1, 16'h0000},
        '{3'd2, 8'h08, 16'hC3C3, 1'b0, 8'h20, 4'd0, 2'd0, 16'h0000},
        '{3'd3, 8'h13, 16'h0000, 1'b1, 8'h00, 4'd2, 2'd0, 16'h0000},
        '{3'd3, 8'h25, 16'h0000, 1'b0, 8'h20, 4'd0, 2'd2, 16'h0000},
        '{3'd3, 8'h31, 16'h0000, 1'b0, 8'h02, 4'd1, 2'd2, 16'h0000},
        '{3'd0, 8'h00, 16'h0000, 1'b0, 8'h00, 4'd0, 2'd0, 16'h0000},
        '{3'd2, 8'h3F, 16'h7E7E, 1'b0, 8'h00, 4'd7, 2'd0, 16'h0000},
        '{3'd3, 8'h00, 16'h0000, 1'b0, 8'h00, 4'd0, 2'd0, 16'h0000}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        vec_t v;
        int blk;
        logic [NB-1:0] lk;
        repeat (3) @(negedge clk);
        // reset state, R10
        chk(busy === 1'b0, "R10", "busy in reset", int'(busy), 0);
        chk(fl_req === 1'b0, "R10", "fl_req in reset", int'(fl_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0, "R10", "done after reset", int'(done), 0);
        chk(busy === 1'b0, "R10", "idle after reset", int'(busy), 0);

        for (int k = 0; k < 13; k++) begin
            v = VECS[k];
            blk = int'(v.addr[5:4]);
            lk = '0;
            if (v.lk) lk[blk] = 1'b1;
            prep(lk, v.ij, -1, int'(v.b), 1'b0);
            run_op(v.op, v.addr, v.data);
            chk(result == v.res, "R6/R7 result", $sformatf("vector %0d code", k), int'(result), int'(v.res));
            chk(wd(s_wr) == 16'h00FF, "R1", "first write", wd(s_wr), 16'h00FF);
            chk(wd(n_wr - 1) == 16'h00FF, "R1", "last write", wd(n_wr - 1), 16'h00FF);
            @(negedge clk);
            chk(done === 1'b0, "R10", "done pulse width", int'(done), 0);
            case (v.op)
                3'd0: chk(n_wr - s_wr == 1, "R10", "reset write count", n_wr - s_wr, 1);
                3'd1: begin // R3
                    chk(id_word == v.id, "R3", "identifier word", int'(id_word), int'(v.id));
                    chk(wd(s_wr + 1) == 16'h0090, "R3", "ident command", wd(s_wr + 1), 16'h0090);
                end
                3'd2: begin // R5 R6
                    chk(wd(s_wr + 1) == 16'h0010, "R5", "program setup", wd(s_wr + 1), 16'h0010);
                    chk(wd(s_wr + 2) == int'(v.data), "R5", "program data", wd(s_wr + 2), int'(v.data));
                    chk(n_sread - s_sr == int'(v.b) + 1, "R6", "status reads", n_sread - s_sr, int'(v.b) + 1);
                    if (v.res == 2'd0) begin
                        chk(mem[v.addr[5:0]] == v.data, "R5", "programmed word", int'(mem[v.addr[5:0]]), int'(v.data));
                        chk(wd(n_wr - 2) == 16'h0050, "R5", "clear before exit", wd(n_wr - 2), 16'h0050);
                    end else begin
                        chk(n_clr == s_clr, "R6", "no clear on failure", n_clr - s_clr, 0);
                    end
                end
                default: begin // R4 R7
                    chk(int'(log_a[(s_wr + 1) % 1024]) == blk * BW + 2, "R4", "lock query address",
                        int'(log_a[(s_wr + 1) % 1024]), blk * BW + 2);
                    if (v.lk) begin
                        chk(wd(s_wr + 3) == 16'h0060, "R4", "unlock setup", wd(s_wr + 3), 16'h0060);
                        chk(wd(s_wr + 4) == 16'h00D0, "R4", "unlock confirm", wd(s_wr + 4), 16'h00D0);
                        chk(n_unl - s_unl == 1, "R4", "unlock count", n_unl - s_unl, 1);
                    end else begin
                        chk(n_unl == s_unl, "R4", "no unlock when clear", n_unl - s_unl, 0);
                        chk(wd(s_wr + 3) == 16'h0050, "R7", "status clear", wd(s_wr + 3), 16'h0050);
                        chk(wd(s_wr + 4) == 16'h0020, "R7", "erase setup", wd(s_wr + 4), 16'h0020);
                    end
                    for (int w = 0; w < BW; w++) begin
                        if (mem[blk * BW + w] != ((v.res == 2'd0) ? 16'hFFFF : 16'h1111))
                            chk(1'b0, "R7", $sformatf("block word %0d", w), int'(mem[blk * BW + w]),
                                (v.res == 2'd0) ? 16'hFFFF : 16'h1111);
                    end
                    checks++;
                end
            endcase
        end

        // R9: program timeout
        prep('0, 8'h00, -1, 0, 1'b1);
        run_op(3'd2, 8'h09, 16'h1357);
        chk(result == 2'd1, "R9", "program timeout code", int'(result), 1);
        chk(n_sread - s_sr == PL, "R9", "program poll count", n_sread - s_sr, PL);
        chk(wd(n_wr - 1) == 16'h00FF, "R9", "exit after timeout", wd(n_wr - 1), 16'h00FF);
        // R9: erase timeout
        prep('0, 8'h00, -1, 0, 1'b1);
        run_op(3'd3, 8'h10, 16'h0000);
        chk(result == 2'd2, "R9", "erase timeout code", int'(result), 2);
        chk(n_sread - s_sr == PL, "R9", "erase poll count", n_sread - s_sr, PL);

        // R8: full chip erase with block 1 locked
        prep(4'b0010, 8'h00, -1, 1, 1'b0);
        run_op(3'd4, 8'h00, 16'h0000);
        chk(result == 2'd0, "R8", "chip erase code", int'(result), 0);
        chk(n_unl - s_unl == 1, "R8", "unlocks in chip erase", n_unl - s_unl, 1);
        for (int b = 0; b < NB; b++)
            chk(mem[b * BW + 5] == 16'hFFFF, "R8", $sformatf("block %0d erased", b), int'(mem[b * BW + 5]), 16'hFFFF);
        chk(int'(log_a[s_wr % 1024]) == 0, "R8", "first block base", int'(log_a[s_wr % 1024]), 0);

        // R8: chip erase stops at failing block 2
        prep('0, 8'h20, 2, 0, 1'b0);
        run_op(3'd4, 8'h00, 16'h0000);
        chk(result == 2'd2, "R8", "chip erase failure code", int'(result), 2);
        chk(mem[1 * BW] == 16'hFFFF, "R8", "block 1 erased", int'(mem[1 * BW]), 16'hFFFF);
        chk(mem[2 * BW] == 16'h1111, "R8", "block 2 kept", int'(mem[2 * BW]), 16'h1111);
        chk(mem[3 * BW] == 16'h1111, "R8", "block 3 untouched", int'(mem[3 * BW]), 16'h1111);
        chk(n_sread - s_sr == 3, "R8", "blocks polled", n_sread - s_sr, 3);

        // R10: illegal op code not accepted
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd6;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b0, "R10", "illegal op ignored", int'(busy), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule